// File: doc/BRIEF.md
# Two-Channel Crossing-Sharing Link Multiplexer

This block merges the 8-bit results of two neighbouring trigger channels onto a single 10-bit output link. Each link word holds an 8-bit data value, a flag and a parity bit. The flag says which channel the data belongs to. A trigger result may not be followed at once by another one: every nonzero value in a channel must be followed by at least one empty crossing. The block relies on that gap. When both channels carry a value in the same crossing, channel A goes out in that crossing and channel B is held and sent in the following crossing. The flag marks B's word as delayed.

In normal mode the parity bit gives the whole 10-bit word an odd number of ones. A bypass input turns off the multiplexing. Channel A's value is then passed through with the same latency, and the parity position carries the lowest data bit instead of a parity value. A nonzero input that arrives while a held value occupies the link breaks the empty-crossing rule. That input is discarded and a saturating error counter advances. A synchronous reset clears the held value, the output word and the counter.

Top module: `xing_pair_mux`

## Requirements
- R1: When only chan_a is nonzero at a sampling edge, the link after that edge shows link_data = chan_a and link_flag = 0.
- R2: When only chan_b is nonzero at a sampling edge, the link after that edge shows link_data = chan_b and link_flag = 1.
- R3: When both channels are nonzero at edge n, the link after edge n shows chan_a with flag 0. After edge n+1 it shows the chan_b value sampled at edge n, with flag 1.
- R4: When both channels are zero and no value is held, the link shows data 0 and flag 0.
- R5: In normal mode the 10-bit word {link_parity, link_flag, link_data} always holds an odd number of ones.
- R6: With bypass = 1 at an edge, the link after that edge shows link_data = chan_a, link_flag = 0 and link_parity = chan_a[0]. chan_b has no effect, and any held value is discarded.
- R7: A nonzero chan_a or chan_b sampled while a held chan_b value is being sent is dropped and never reaches the link. err_count increases by exactly 1 for that crossing.
- R8: err_count saturates at its all-ones value (255 by default) and does not wrap.
- R9: With rst = 1 at an edge, after that edge link_data = 0, link_flag = 0, link_parity = 1 and err_count = 0. A held value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| bypass | input | 1 | 1 passes channel A straight to the link |
| chan_a | input | 8 | Channel A result, 0 means empty |
| chan_b | input | 8 | Channel B result, 0 means empty |
| link_data | output | 8 | Data byte of the link word |
| link_flag | output | 1 | 0 = channel A, current crossing; 1 = channel B, possibly delayed |
| link_parity | output | 1 | Odd-parity bit, or chan_a[0] in bypass |
| err_count | output | 8 | Saturating count of dropped conflicting inputs |

## Verification
Each link word is registered once. A word formed from the inputs sampled at an edge is therefore visible right after that edge, and a held channel B value appears one edge later. The error counter reaches its new value after the same edge that sampled the offending input. The bench applies inputs a short delay after a rising edge and checks every output the same short delay after the next rising edge. It works out expected parity with its own bit-counting loop.

// File: rtl/xmux_pkg.sv
package xmux_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_HELD = 2'd3
  } src_e;
endpackage

// File: rtl/xmux_sched.sv
module xmux_sched
  import xmux_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] sel_data,
  output logic              sel_flag,
  output logic              conflict
);
  logic              hold_v;
  logic [DATA_W-1:0] hold_val;
  logic              a_busy, b_busy;
  src_e              src;

  assign a_busy = (a_in != '0);
  assign b_busy = (b_in != '0);

  // Any activity while the held slot is in use breaks the empty-crossing rule.
  assign conflict = !bypass && hold_v && (a_busy || b_busy);

  always_comb begin
    if (hold_v)      src = SRC_HELD;
    else if (a_busy) src = SRC_A;
    else if (b_busy) src = SRC_B;
    else             src = SRC_IDLE;
  end

  always_comb begin
    case (src)
      SRC_A:    begin sel_data = a_in;     sel_flag = 1'b0; end
      SRC_B:    begin sel_data = b_in;     sel_flag = 1'b1; end
      SRC_HELD: begin sel_data = hold_val; sel_flag = 1'b1; end
      default:  begin sel_data = '0;       sel_flag = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || bypass) begin
      hold_v   <= 1'b0;
      hold_val <= '0;
    end else if (!hold_v && a_busy && b_busy) begin
      hold_v   <= 1'b1;
      hold_val <= b_in;
    end else begin
      hold_v   <= 1'b0;
    end
  end

  // R3: a held slot is always followed by a free one
  assert_hold_single_R3: assert property (@(posedge clk) disable iff (rst)
    hold_v |=> !hold_v);

  // R3: while a value is held, the selected word is flagged as channel B
  assert_held_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !bypass) |-> (sel_flag && sel_data != '0));

  // R7: conflicts only arise in a held crossing
  assert_conflict_slot_R7: assert property (@(posedge clk) disable iff (rst)
    conflict |-> (src == SRC_HELD));
endmodule

// File: rtl/xmux_frame.sv
module xmux_frame #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] sel_data,
  input  logic              sel_flag,
  output logic [DATA_W-1:0] link_data,
  output logic              link_flag,
  output logic              link_par
);
  logic mode_byp_q;

  // Parity bit that gives {par, flag, data} an odd number of ones.
  function automatic logic odd_fill(input logic [DATA_W-1:0] d, input logic f);
    return ~(^{f, d});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      link_data  <= '0;
      link_flag  <= 1'b0;
      link_par   <= 1'b1;
      mode_byp_q <= 1'b0;
    end else if (bypass) begin
      link_data  <= a_in;
      link_flag  <= 1'b0;
      link_par   <= a_in[0];
      mode_byp_q <= 1'b1;
    end else begin
      link_data  <= sel_data;
      link_flag  <= sel_flag;
      link_par   <= odd_fill(sel_data, sel_flag);
      mode_byp_q <= 1'b0;
    end
  end

  // R5: odd parity over the full link word in normal mode
  assert_odd_word_R5: assert property (@(posedge clk) disable iff (rst)
    !mode_byp_q |-> ($countones({link_par, link_flag, link_data}) % 2 == 1));

  // R6: bypass words carry the low data bit and a clear flag
  assert_bypass_word_R6: assert property (@(posedge clk) disable iff (rst)
    mode_byp_q |-> (link_par == link_data[0] && !link_flag));
endmodule

// File: rtl/xmux_errcnt.sv
module xmux_errcnt #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  output logic [ERR_W-1:0] count
);
  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                         count <= '0;
    else if (hit && count != CNT_MAX) count <= count + 1'b1;
  end

  // R7: one step per conflicting crossing until saturation
  assert_err_step_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

  // R8: saturated counter stays put
  assert_err_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX) |=> (count == CNT_MAX));

  // R7: counter moves only on a conflict
  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(count));
endmodule

// File: rtl/xing_pair_mux.sv
module xing_pair_mux #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic [DATA_W-1:0] chan_a,
  input  logic [DATA_W-1:0] chan_b,
  output logic [DATA_W-1:0] link_data,
  output logic              link_flag,
  output logic              link_parity,
  output logic [ERR_W-1:0]  err_count
);
  logic [DATA_W-1:0] sel_data;
  logic              sel_flag;
  logic              conflict;

  xmux_sched #(.DATA_W(DATA_W)) u_sched (
    .clk      (clk),
    .rst      (rst),
    .bypass   (bypass),
    .a_in     (chan_a),
    .b_in     (chan_b),
    .sel_data (sel_data),
    .sel_flag (sel_flag),
    .conflict (conflict)
  );

  xmux_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .bypass    (bypass),
    .a_in      (chan_a),
    .sel_data  (sel_data),
    .sel_flag  (sel_flag),
    .link_data (link_data),
    .link_flag (link_flag),
    .link_par  (link_parity)
  );

  xmux_errcnt #(.ERR_W(ERR_W)) u_err (
    .clk   (clk),
    .rst   (rst),
    .hit   (conflict),
    .count (err_count)
  );
endmodule

// File: tb/xing_pair_mux_test.sv
module xing_pair_mux_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bypass = 1'b0;
  logic [7:0] chan_a = '0;
  logic [7:0] chan_b = '0;
  logic [7:0] link_data;
  logic       link_flag;
  logic       link_parity;
  logic [7:0] err_count;
  int n_run = 0;
  int n_fail = 0;
  int exp_err = 0;

  always #5 clk = ~clk;

  xing_pair_mux uut (
    .clk(clk), .rst(rst), .bypass(bypass), .chan_a(chan_a), .chan_b(chan_b),
    .link_data(link_data), .link_flag(link_flag), .link_parity(link_parity),
    .err_count(err_count)
  );

  function automatic logic want_par(input logic [7:0] d, input logic f);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    ones += f;
    return (ones % 2 == 0);
  endfunction

  // apply inputs, let one edge sample them, then look just after the edge
  task automatic step(input logic [7:0] a, input logic [7:0] b);
    chan_a = a; chan_b = b;
    @(posedge clk); #2;
  endtask

  task automatic chk_word(input string req, input logic [7:0] d, input logic f, input logic p);
    n_run++;
    if (link_data !== d || link_flag !== f || link_parity !== p) begin
      n_fail++;
      $display("FAIL %s: got data=%02h flag=%b par=%b, expected data=%02h flag=%b par=%b",
               req, link_data, link_flag, link_parity, d, f, p);
    end
  endtask

  task automatic chk_norm(input string req, input logic [7:0] d, input logic f);
    chk_word(req, d, f, want_par(d, f));
  endtask

  task automatic chk_err(input string req, input int e);
    n_run++;
    if (err_count !== e[7:0]) begin
      n_fail++;
      $display("FAIL %s: got err_count=%0d, expected %0d", req, err_count, e);
    end
  endtask

  task automatic t_reset_state;
    rst = 1; step(8'h00, 8'h00); step(8'h00, 8'h00);
    chk_word("R9 reset word", 8'h00, 1'b0, 1'b1);
    chk_err("R9 reset count", 0);
    rst = 0;
  endtask

  task automatic t_single_a;
    step(8'h5A, 8'h00); chk_norm("R1 only A", 8'h5A, 1'b0);
    step(8'h00, 8'h00); chk_norm("R4 idle after A", 8'h00, 1'b0);
    step(8'h01, 8'h00); chk_norm("R1 only A low", 8'h01, 1'b0);
    step(8'h00, 8'h00);
  endtask

  task automatic t_single_b;
    step(8'h00, 8'hC3); chk_norm("R2 only B", 8'hC3, 1'b1);
    step(8'h00, 8'h00); chk_norm("R4 idle after B", 8'h00, 1'b0);
    step(8'h00, 8'hFF); chk_norm("R2 only B max", 8'hFF, 1'b1);
    step(8'h00, 8'h00);
  endtask

  task automatic t_both;
    step(8'h12, 8'h34); chk_norm("R3 A first", 8'h12, 1'b0);
    step(8'h00, 8'h00); chk_norm("R3 B delayed", 8'h34, 1'b1);
    step(8'h00, 8'h00); chk_norm("R3 free after held", 8'h00, 1'b0);
    chk_err("R3 no error", exp_err);
  endtask

  task automatic t_parity_sweep;
    for (int v = 1; v < 256; v += 37) begin
      step(v[7:0], 8'h00); chk_norm("R5 parity A", v[7:0], 1'b0);
      step(8'h00, v[7:0]); chk_norm("R5 parity B", v[7:0], 1'b1);
    end
    step(8'h00, 8'h00); chk_norm("R5 parity idle", 8'h00, 1'b0);
  endtask

  task automatic t_conflict;
    step(8'h21, 8'h43); chk_norm("R7 A first", 8'h21, 1'b0);
    step(8'h77, 8'h88); chk_norm("R7 held B wins", 8'h43, 1'b1);
    exp_err++; chk_err("R7 count step", exp_err);
    step(8'h00, 8'h00); chk_norm("R7 dropped stays gone", 8'h00, 1'b0);
    chk_err("R7 count stable", exp_err);
  endtask

  task automatic t_bypass;
    bypass = 1;
    step(8'h6B, 8'h99); chk_word("R6 bypass odd", 8'h6B, 1'b0, 1'b1);
    step(8'h00, 8'hAA); chk_word("R6 B ignored", 8'h00, 1'b0, 1'b0);
    step(8'h84, 8'h11); chk_word("R6 bypass even", 8'h84, 1'b0, 1'b0);
    bypass = 0;
    step(8'h10, 8'h20); chk_norm("R6 normal again", 8'h10, 1'b0);
    bypass = 1;
    step(8'h00, 8'h00); chk_word("R6 hold discarded", 8'h00, 1'b0, 1'b0);
    bypass = 0;
    step(8'h00, 8'h00); chk_norm("R6 no late B", 8'h00, 1'b0);
    chk_err("R6 no error in bypass", exp_err);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 260; i++) begin
      step(8'h05, 8'h06);
      step(8'h07, 8'h00);
      if (exp_err < 255) exp_err++;
    end
    step(8'h00, 8'h00);
    chk_err("R8 saturated", 255);
  endtask

  task automatic t_reset_mid;
    step(8'h31, 8'h32);
    rst = 1; step(8'h00, 8'h00);
    chk_word("R9 reset clears word", 8'h00, 1'b0, 1'b1);
    chk_err("R9 reset clears count", 0);
    rst = 0; exp_err = 0;
    step(8'h00, 8'h00); chk_norm("R9 held value gone", 8'h00, 1'b0);
  endtask

  initial begin
    #2;
    t_reset_state();
    t_single_a();
    t_single_b();
    t_both();
    t_parity_sweep();
    t_conflict();
    t_bypass();
    t_saturate();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule